// File: doc/BRIEF.md
# Per-Register Sample Stream Buffer

This block sits behind one data register of an emulated bus peripheral whose value changes over time. A producer side delivers samples into a small bounded queue. The register read path takes one sample from that queue for each byte that the bus side confirms as delivered. The byte on offer is visible at all times. It is consumed only when the bus side raises a one-cycle read strobe, so sampling the output repeatedly does not use up samples.

The buffer never stalls the bus. When a read arrives on an empty queue, the block serves the last delivered byte again and counts an underrun. Before any byte has been delivered, it serves the register default instead. When a sample arrives on a full queue, the block discards it and counts a drop. Both counters saturate at their maximum. Fill level and free space are reported so the producer can pace itself.

A second mode replays a fixed series of values, given as a parameter, in a loop. It does not draw from the queue. A synchronous clear returns the queue, the counters, the last delivered value and the replay position to their reset state.

Top module: `sample_stream_buf`

## Requirements
- R1: After reset, the block reports the following: `fillLevel` is 0, `freeSpace` equals DEPTH, both counters are 0, `lastValue` equals DEFAULT_VAL, and in queue mode `readData` equals DEFAULT_VAL.
- R2: In queue mode (`seqMode`=0), `readData` shows the oldest stored sample. Each `readStrobe` removes exactly that sample, so samples leave in the order they were pushed.
- R3: Without `readStrobe`, no sample is consumed. `readData` and `fillLevel` keep their values while no push occurs.
- R4: `fillLevel + freeSpace` equals DEPTH in every cycle.
- R5: A push while `fillLevel` equals DEPTH and no queue-mode read is strobed is discarded. `dropCount` rises by one and the stored samples are unchanged.
- R6: A queue-mode `readStrobe` while the queue is empty raises `underrunCount` by one. During that cycle `readData` equals `lastValue`, which is DEFAULT_VAL if nothing has been delivered since reset or clear.
- R7: A push and a queue-mode read in the same cycle are both carried out, and `fillLevel` is left unchanged. This includes the case where the queue is full, in which the push is accepted.
- R8: `dropCount` and `underrunCount` stop at 2^CNT_W-1 instead of wrapping.
- R9: `clear` acts at the next clock edge and overrides any push or read in that cycle. It empties the queue, zeroes both counters, sets `lastValue` to DEFAULT_VAL and returns the replay position to entry 0.
- R10: In replay mode (`seqMode`=1), `readData` shows entry k of SEQ_INIT, where entry k occupies bits [k*DATA_W +: DATA_W]. Each `readStrobe` advances k, and k wraps from SEQ_LEN-1 to 0. A replay read neither touches the queue nor counts an underrun.
- R11: After each `readStrobe`, `lastValue` holds the byte that `readData` showed in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of queue, counters, last value and replay position |
| seqMode | input | 1 | 0: serve from queue, 1: replay fixed series |
| pushValid | input | 1 | Producer offers a sample this cycle |
| pushData | input | DATA_W | Sample from producer |
| readStrobe | input | 1 | Bus side confirms one byte delivered |
| readData | output | DATA_W | Byte currently on offer to the bus |
| fillLevel | output | $clog2(DEPTH+1) | Samples held |
| freeSpace | output | $clog2(DEPTH+1) | Free slots |
| dropCount | output | CNT_W | Saturating count of discarded pushes |
| underrunCount | output | CNT_W | Saturating count of empty-queue reads |
| lastValue | output | DATA_W | Last byte delivered to the bus |

## Verification
The bench builds the block with DEPTH=4, CNT_W=3, a three-entry replay series and DEFAULT_VAL=8'hA5. The shallow queue makes the full-queue drop and the push-while-full-and-reading case reachable within a handful of pushes. The three-bit counters make saturation at 7 reachable within about a dozen reads or pushes. The three-entry series makes the replay wrap, which crosses a non-power-of-two length, occur within four reads.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  // Strobes issued by control to the datapath each cycle.
  typedef struct packed {
    logic clr;       // synchronous clear
    logic push;      // store pushData
    logic pop;       // remove head sample
    logic drop;      // push discarded
    logic underrun;  // empty-queue read
    logic seqStep;   // advance replay position
    logic deliver;   // latch served byte as last value
  } ssbStrobes_t;
endpackage

// File: rtl/ssb_satcnt.sv
module ssb_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != MAX)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic        clear,
  input  logic        seqMode,
  input  logic        pushValid,
  input  logic        readStrobe,
  input  logic        isEmpty,
  input  logic        isFull,
  output ssbStrobes_t strb
);
  logic fifoRead;

  always_comb begin
    fifoRead      = readStrobe && !seqMode && !clear;
    strb.clr      = clear;
    strb.pop      = fifoRead && !isEmpty;
    strb.underrun = fifoRead && isEmpty;
    // A pop in the same cycle frees a slot, so a full queue still accepts.
    strb.push     = pushValid && !clear && (!isFull || strb.pop);
    strb.drop     = pushValid && !clear && isFull && !strb.pop;
    strb.seqStep  = readStrobe && seqMode && !clear;
    strb.deliver  = readStrobe && !clear;
  end
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int                     DATA_W      = 8,
  parameter int                     DEPTH       = 16,
  parameter int                     CNT_W       = 8,
  parameter int                     SEQ_LEN     = 4,
  parameter logic [SEQ_LEN*DATA_W-1:0] SEQ_INIT = '0,
  parameter logic [DATA_W-1:0]      DEFAULT_VAL = '0,
  localparam int                    LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqMode,
  input  logic [DATA_W-1:0] pushData,
  input  ssbStrobes_t       strb,
  output logic [DATA_W-1:0] readData,
  output logic [LVL_W-1:0]  fillLevel,
  output logic [LVL_W-1:0]  freeSpace,
  output logic [CNT_W-1:0]  dropCount,
  output logic [CNT_W-1:0]  underrunCount,
  output logic [DATA_W-1:0] lastValue,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SEQ_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_LEN - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [SEQ_W-1:0]  seqIdx;
  logic [DATA_W-1:0] seqVal, headVal;

  assign isEmpty   = (fillLevel == '0);
  assign isFull    = (fillLevel == LVL_W'(DEPTH));
  assign freeSpace = LVL_W'(DEPTH) - fillLevel;
  assign seqVal    = SEQ_INIT[32'(seqIdx) * DATA_W +: DATA_W];
  assign headVal   = store[rdPtr];

  always_comb begin
    if (seqMode)       readData = seqVal;
    else if (!isEmpty) readData = headVal;
    else               readData = lastValue;
  end

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      seqIdx    <= '0;
      lastValue <= DEFAULT_VAL;
    end else if (strb.clr) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      seqIdx    <= '0;
      lastValue <= DEFAULT_VAL;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      if (strb.seqStep) seqIdx <= (seqIdx == SEQ_LAST) ? '0 : seqIdx + 1'b1;
      if (strb.deliver) lastValue <= readData;
    end
  end

  ssb_satcnt #(.W(CNT_W)) uDropCnt (
    .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(strb.drop), .cnt(dropCount)
  );
  ssb_satcnt #(.W(CNT_W)) uUnderCnt (
    .clk(clk), .rstN(rstN), .clr(strb.clr), .inc(strb.underrun), .cnt(underrunCount)
  );
endmodule

// File: rtl/sample_stream_buf.sv
module sample_stream_buf
  import ssb_pkg::*;
#(
  parameter int                        DATA_W      = 8,
  parameter int                        DEPTH       = 16,
  parameter int                        CNT_W       = 8,
  parameter int                        SEQ_LEN     = 4,
  parameter logic [SEQ_LEN*DATA_W-1:0] SEQ_INIT    = 32'h4030_2010,
  parameter logic [DATA_W-1:0]         DEFAULT_VAL = 8'hFF,
  localparam int                       LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              seqMode,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] readData,
  output logic [LVL_W-1:0]  fillLevel,
  output logic [LVL_W-1:0]  freeSpace,
  output logic [CNT_W-1:0]  dropCount,
  output logic [CNT_W-1:0]  underrunCount,
  output logic [DATA_W-1:0] lastValue
);
  ssbStrobes_t strb;
  logic        isEmpty, isFull;

  ssb_ctrl uCtrl (
    .clear(clear), .seqMode(seqMode), .pushValid(pushValid),
    .readStrobe(readStrobe), .isEmpty(isEmpty), .isFull(isFull), .strb(strb)
  );

  ssb_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SEQ_LEN(SEQ_LEN),
    .SEQ_INIT(SEQ_INIT), .DEFAULT_VAL(DEFAULT_VAL)
  ) uDp (
    .clk(clk), .rstN(rstN), .seqMode(seqMode), .pushData(pushData), .strb(strb),
    .readData(readData), .fillLevel(fillLevel), .freeSpace(freeSpace),
    .dropCount(dropCount), .underrunCount(underrunCount), .lastValue(lastValue),
    .isEmpty(isEmpty), .isFull(isFull)
  );
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              seqMode,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushData,
  input logic              readStrobe,
  input logic [DATA_W-1:0] readData,
  input logic [LVL_W-1:0]  fillLevel,
  input logic [LVL_W-1:0]  freeSpace,
  input logic [CNT_W-1:0]  dropCount,
  input logic [CNT_W-1:0]  underrunCount,
  input logic [DATA_W-1:0] lastValue
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  // R4
  level_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(fillLevel) + 32'(freeSpace) == DEPTH);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !pushValid && !readStrobe) |=> $stable(fillLevel) && $stable(readData));

  // R5
  drop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && pushValid && fillLevel == FULL && !(readStrobe && !seqMode) && dropCount != CMAX)
      |=> dropCount == $past(dropCount) + 1'b1);

  // R6
  underrun_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && readStrobe && !seqMode && fillLevel == '0 && underrunCount != CMAX)
      |=> underrunCount == $past(underrunCount) + 1'b1);

  // R6
  underrun_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !seqMode && fillLevel == '0) |-> readData == lastValue);

  // R7
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && pushValid && readStrobe && !seqMode && fillLevel != '0) |=> $stable(fillLevel));

  // R8
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && dropCount == CMAX) |=> dropCount == CMAX);

  // R8
  under_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && underrunCount == CMAX) |=> underrunCount == CMAX);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> fillLevel == '0 && dropCount == '0 && underrunCount == '0);

  // R10
  seq_no_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && seqMode) |=> $stable(underrunCount) && $stable(fillLevel) || $past(pushValid));

  // R11
  last_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && readStrobe) |=> lastValue == $past(readData));
endmodule

bind sample_stream_buf ssb_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) uChk (.*);

// File: tb/sim_sample_stream_buf.sv
module sim_sample_stream_buf;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 3;
  localparam int SEQ_LEN = 3;
  localparam logic [SEQ_LEN*DATA_W-1:0] SEQ_INIT = 24'h33_22_11;
  localparam logic [DATA_W-1:0] DEF = 8'hA5;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, seqMode = 1'b0;
  logic pushValid = 1'b0, readStrobe = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic [DATA_W-1:0] readData, lastValue;
  logic [LVL_W-1:0]  fillLevel, freeSpace;
  logic [CNT_W-1:0]  dropCount, underrunCount;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Scoreboard state: expected queue contents and expected status.
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] expLast = DEF;
  int expDrop = 0, expUnder = 0, expSeq = 0;

  always #2 clk = ~clk;

  sample_stream_buf #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SEQ_LEN(SEQ_LEN),
    .SEQ_INIT(SEQ_INIT), .DEFAULT_VAL(DEF)
  ) u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkStatus(string req);
    check({req, " fillLevel"}, int'(fillLevel), expQ.size());
    check({req, " freeSpace"}, int'(freeSpace), DEPTH - expQ.size());
    check({req, " dropCount"}, int'(dropCount), expDrop);
    check({req, " underrunCount"}, int'(underrunCount), expUnder);
    check({req, " lastValue"}, int'(lastValue), int'(expLast));
  endtask

  // Driver: one cycle with optional push and read; called at a negedge.
  task automatic cyc(bit pv, logic [DATA_W-1:0] pd, bit rd, string req);
    logic [DATA_W-1:0] served;
    bit wasFull, popped;
    pushValid = pv; pushData = pd; readStrobe = rd;
    served = seqMode ? SEQ_INIT[expSeq*DATA_W +: DATA_W]
                     : (expQ.size() != 0 ? expQ[0] : expLast);
    if (rd) check({req, " readData"}, int'(readData), int'(served));
    wasFull = (expQ.size() == DEPTH);
    popped  = 1'b0;
    if (rd && !seqMode) begin
      if (expQ.size() != 0) begin void'(expQ.pop_front()); popped = 1'b1; end
      else if (expUnder < CMAX) expUnder++;
    end
    if (rd && seqMode) expSeq = (expSeq == SEQ_LEN - 1) ? 0 : expSeq + 1;
    if (rd) expLast = served;
    if (pv) begin
      if (wasFull && !popped) begin if (expDrop < CMAX) expDrop++; end
      else expQ.push_back(pd);
    end
    @(negedge clk);
    pushValid = 1'b0; readStrobe = 1'b0;
    checkStatus(req);
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    expQ.delete(); expDrop = 0; expUnder = 0; expSeq = 0; expLast = DEF;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkStatus("R1");
    check("R1 readData", int'(readData), int'(DEF));

    // R2 order, R4 and R11 through status
    cyc(1, 8'h01, 0, "R2");
    cyc(1, 8'h02, 0, "R2");
    cyc(1, 8'h03, 0, "R2");
    // R3 idle cycles consume nothing
    held = readData;
    repeat (3) @(negedge clk);
    check("R3 readData", int'(readData), int'(held));
    checkStatus("R3");
    cyc(0, 8'h00, 1, "R2");
    cyc(0, 8'h00, 1, "R11");
    // R7 push and pop together, partial
    cyc(1, 8'h04, 1, "R7");
    cyc(0, 8'h00, 1, "R2");

    // R6 underrun repeats last
    cyc(0, 8'h00, 1, "R6");
    cyc(0, 8'h00, 1, "R6");

    // R5 drops on full, contents kept
    for (int i = 0; i < 6; i++) cyc(1, 8'h10 + 8'(i), 0, "R5");
    // R7 full with push and read
    cyc(1, 8'h50, 1, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1, "R5");

    // R8 saturation of both counters
    for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 8'h60 + 8'(i), 0, "R8");
    for (int i = 0; i < 9; i++) cyc(1, 8'h70, 0, "R8");

    // R10 replay mode: queue stays full, no underrun
    seqMode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) cyc(0, 8'h00, 1, "R10");

    // R9 clear overrides a simultaneous read and push
    pushValid = 1'b1; readStrobe = 1'b1; pushData = 8'h99;
    doClear();
    pushValid = 1'b0; readStrobe = 1'b0;
    checkStatus("R9");
    check("R9 seq restart", int'(readData), int'(SEQ_INIT[7:0]));
    seqMode = 1'b0;
    @(negedge clk);
    cyc(0, 8'h00, 1, "R9 default after clear");
    cyc(1, 8'hC3, 0, "R2");
    cyc(1, 8'hC4, 1, "R2");
    cyc(0, 8'h00, 1, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule